// File: doc/BRIEF.md
# Guarded Escape Sequence Detector

This block sits beside a UART receiver and watches the stream of received bytes for an escape sequence: a quiet period on the line, then a run of identical command characters that arrive close together, then a second quiet period. Only when the whole pattern has been seen does it emit a single-cycle detection pulse. Because the guard times before and after the run are part of the pattern, a command character inside ordinary traffic never triggers a detection.

Bytes enter on a valid/ready stream. The detector never applies back-pressure: `in_ready` is high in every cycle after reset, and a byte is taken in any cycle where `in_valid` is high. All durations count in bit-time ticks (`bit_tick`). Guard time accumulates only while the receiver reports an idle line (`rx_idle`). The five settings are held in internal registers that load together on a `cfg_load` strobe and start from fixed reset values.

Top module: `esc_seq_detect`

## Requirements
- R1: After reset the settings are command character 0x2B, run length 3, pre-guard 2305 ticks, post-guard 2305 ticks and gap limit 11 ticks; `dbg_state` is 0, `detect` is low and `in_ready` is high.
- R2: `in_ready` is high in every cycle out of reset, so every byte presented with `in_valid` is consumed in that cycle.
- R3: In the pre-guard state the guard counter advances by one on each cycle with `bit_tick` high, `rx_idle` high and no byte; a byte or a low `rx_idle` clears it; the cycle after the counter has reached the pre-guard length the state becomes armed.
- R4: A byte that differs from the command character, received while armed or inside the run, returns the block to the pre-guard state with the guard measured from that byte.
- R5: The run is complete after the programmed number of consecutive command characters; a programmed count of 0 behaves as 1.
- R6: Inside the run, a tick that arrives when the gap counter (ticks since the last command character) already equals the gap limit abandons the run and returns to the pre-guard state; a command character beats a tick in the same cycle.
- R7: Any byte received during the post-guard state, including the command character, returns to the pre-guard state and produces no detection.
- R8: `detect` is high for exactly one cycle, the cycle after the post-guard counter (same advance and clear rules as R3) has reached the post-guard length, and the state is then back in pre-guard.
- R9: `dbg_state` encodes pre-guard as 0, armed as 1, inside-run as 2 and post-guard as 3.
- R10: A cycle with `cfg_load` high copies all five setting inputs into the registers; the new values govern behaviour from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Received byte present |
| in_ready | output | 1 | Byte accepted (high whenever out of reset) |
| in_data | input | 8 | Received byte |
| rx_idle | input | 1 | Receiver reports an idle line |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| cfg_load | input | 1 | Load strobe for the five settings |
| cfg_char | input | 8 | Command character to load |
| cfg_count | input | 8 | Run length to load |
| cfg_pre_idle | input | 16 | Pre-guard length in ticks to load |
| cfg_post_idle | input | 16 | Post-guard length in ticks to load |
| cfg_gap | input | 16 | Gap limit in ticks to load |
| detect | output | 1 | One-cycle detection pulse |
| dbg_state | output | 2 | Sequencer state (see R9) |

## Verification
The hardest situation to reach is the narrow window where the run is abandoned by the gap limit but the pre-guard has not yet re-armed the block, since both depend on tick counts after the same byte. The stimulus slows the tick to every other cycle and uses small loaded settings so the window spans several cycles, and a behavioural model compared every clock pins down the exact cycle of each transition. Default settings are exercised once end to end with a tick in every cycle so the 2305-tick guards finish quickly.

// File: rtl/esc_seq_pkg.sv
package esc_seq_pkg;

  localparam int unsigned CHAR_W = 8;
  localparam int unsigned RUN_W  = 8;
  localparam int unsigned TIME_W = 16;

  typedef enum logic [1:0] {
    ST_PRE_GUARD  = 2'd0,
    ST_ARMED      = 2'd1,
    ST_IN_RUN     = 2'd2,
    ST_POST_GUARD = 2'd3
  } esc_state_e;

  typedef struct packed {
    logic [CHAR_W-1:0] cmd_char;
    logic [RUN_W-1:0]  run_len;
    logic [TIME_W-1:0] pre_len;
    logic [TIME_W-1:0] post_len;
    logic [TIME_W-1:0] gap_lim;
  } esc_cfg_t;

endpackage

// File: rtl/esc_cfg_regs.sv
module esc_cfg_regs
  import esc_seq_pkg::*;
#(
  parameter logic [CHAR_W-1:0] DEF_CHAR = 8'h2B,
  parameter logic [RUN_W-1:0]  DEF_RUN  = 8'd3,
  parameter logic [TIME_W-1:0] DEF_PRE  = 16'd2305,
  parameter logic [TIME_W-1:0] DEF_POST = 16'd2305,
  parameter logic [TIME_W-1:0] DEF_GAP  = 16'd11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  esc_cfg_t          cfg_d,
  output esc_cfg_t          cfg_q,
  output logic [RUN_W-1:0]  need
);

  esc_cfg_t cfg_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_r.cmd_char <= DEF_CHAR;
      cfg_r.run_len  <= DEF_RUN;
      cfg_r.pre_len  <= DEF_PRE;
      cfg_r.post_len <= DEF_POST;
      cfg_r.gap_lim  <= DEF_GAP;
    end else if (load) begin
      cfg_r <= cfg_d;
    end
  end

  assign cfg_q = cfg_r;
  // a run length of zero is promoted to one
  assign need  = (cfg_r.run_len == '0) ? RUN_W'(1) : cfg_r.run_len;

  a_r10_load_takes: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cfg_q == $past(cfg_d)));

  a_r5_need_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    need != '0);

endmodule

// File: rtl/esc_tick_timer.sv
module esc_tick_timer #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         advance,
  input  logic [W-1:0] limit,
  output logic         reached
);

  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      cnt_q <= '0;
    end else if (advance && cnt_q != CNT_MAX) begin
      cnt_q <= cnt_q + W'(1);
    end
  end

  assign reached = (cnt_q >= limit);

  // R3 / R8: the count only moves forward unless cleared
  a_r3_count_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> (cnt_q >= $past(cnt_q)));

  a_r3_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt_q == '0));

endmodule

// File: rtl/esc_seq_fsm.sv
module esc_seq_fsm
  import esc_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [CHAR_W-1:0] in_data,
  input  logic              rx_idle,
  input  logic              bit_tick,
  input  logic [CHAR_W-1:0] cmd_char,
  input  logic [RUN_W-1:0]  need,
  input  logic              guard_met,
  input  logic              gap_expired,
  output esc_state_e        state,
  output logic              guard_clear,
  output logic              guard_adv,
  output logic              gap_clear,
  output logic              gap_adv,
  output logic              detect
);

  esc_state_e st_q, st_d;
  logic [RUN_W-1:0] seen_q, seen_d;
  logic             det_q, det_d;
  logic             hit;
  logic             in_guard;
  logic [RUN_W:0]   seen_inc;

  assign hit      = in_valid && (in_data == cmd_char);
  assign in_guard = (st_q == ST_PRE_GUARD) || (st_q == ST_POST_GUARD);
  assign seen_inc = {1'b0, seen_q} + (RUN_W+1)'(1);

  always_comb begin
    st_d   = st_q;
    seen_d = seen_q;
    det_d  = 1'b0;
    unique case (st_q)
      ST_PRE_GUARD: begin
        if (!in_valid && guard_met) st_d = ST_ARMED;
      end
      ST_ARMED: begin
        if (in_valid) begin
          if (!hit) begin
            st_d = ST_PRE_GUARD;
          end else if (need == RUN_W'(1)) begin
            st_d = ST_POST_GUARD;
          end else begin
            st_d   = ST_IN_RUN;
            seen_d = RUN_W'(1);
          end
        end
      end
      ST_IN_RUN: begin
        if (in_valid) begin
          if (!hit) begin
            st_d = ST_PRE_GUARD;
          end else if (seen_inc >= {1'b0, need}) begin
            st_d = ST_POST_GUARD;
          end else begin
            seen_d = seen_inc[RUN_W-1:0];
          end
        end else if (bit_tick && gap_expired) begin
          st_d = ST_PRE_GUARD;
        end
      end
      ST_POST_GUARD: begin
        if (in_valid) begin
          st_d = ST_PRE_GUARD;
        end else if (guard_met) begin
          st_d  = ST_PRE_GUARD;
          det_d = 1'b1;
        end
      end
      default: st_d = ST_PRE_GUARD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_PRE_GUARD;
      seen_q <= '0;
      det_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      seen_q <= seen_d;
      det_q  <= det_d;
    end
  end

  // guard counter is kept at zero outside the guard states, so every
  // entry into a guard state starts from zero
  assign guard_clear = in_valid || !rx_idle || !in_guard || (st_q != st_d) || det_d;
  assign guard_adv   = in_guard && bit_tick && rx_idle && !in_valid && !guard_met;
  assign gap_clear   = (st_q != ST_IN_RUN) || in_valid;
  assign gap_adv     = (st_q == ST_IN_RUN) && bit_tick && !in_valid && !gap_expired;

  assign state  = st_q;
  assign detect = det_q;

  a_r4_mismatch_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_data != cmd_char && (st_q == ST_ARMED || st_q == ST_IN_RUN))
      |=> (st_q == ST_PRE_GUARD));

  a_r5_single_char_run: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ARMED && hit && need == RUN_W'(1)) |=> (st_q == ST_POST_GUARD));

  a_r6_gap_abandon: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IN_RUN && !in_valid && bit_tick && gap_expired) |=> (st_q == ST_PRE_GUARD));

  a_r7_post_byte_aborts: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_POST_GUARD && in_valid) |=> (st_q == ST_PRE_GUARD && !detect));

  a_r8_from_post_guard: assert property (@(posedge clk) disable iff (!rst_n)
    detect |-> ($past(st_q) == ST_POST_GUARD && st_q == ST_PRE_GUARD));

  a_r8_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    detect |=> !detect);

endmodule

// File: rtl/esc_seq_detect.sv
module esc_seq_detect
  import esc_seq_pkg::*;
#(
  parameter logic [CHAR_W-1:0] DEF_CHAR = 8'h2B,
  parameter logic [RUN_W-1:0]  DEF_RUN  = 8'd3,
  parameter logic [TIME_W-1:0] DEF_PRE  = 16'd2305,
  parameter logic [TIME_W-1:0] DEF_POST = 16'd2305,
  parameter logic [TIME_W-1:0] DEF_GAP  = 16'd11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CHAR_W-1:0] in_data,
  input  logic              rx_idle,
  input  logic              bit_tick,
  input  logic              cfg_load,
  input  logic [CHAR_W-1:0] cfg_char,
  input  logic [RUN_W-1:0]  cfg_count,
  input  logic [TIME_W-1:0] cfg_pre_idle,
  input  logic [TIME_W-1:0] cfg_post_idle,
  input  logic [TIME_W-1:0] cfg_gap,
  output logic              detect,
  output logic [1:0]        dbg_state
);

  esc_cfg_t         cfg_in, cfg;
  logic [RUN_W-1:0] need;
  esc_state_e       state;
  logic             guard_clear, guard_adv, guard_met;
  logic             gap_clear, gap_adv, gap_expired;
  logic [TIME_W-1:0] guard_lim;
  logic             ready_q;

  assign cfg_in = '{cmd_char: cfg_char, run_len: cfg_count, pre_len: cfg_pre_idle,
                    post_len: cfg_post_idle, gap_lim: cfg_gap};

  esc_cfg_regs #(
    .DEF_CHAR(DEF_CHAR), .DEF_RUN(DEF_RUN), .DEF_PRE(DEF_PRE),
    .DEF_POST(DEF_POST), .DEF_GAP(DEF_GAP)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .load(cfg_load), .cfg_d(cfg_in),
    .cfg_q(cfg), .need(need)
  );

  // one counter serves both guards; its limit follows the state
  assign guard_lim = (state == ST_POST_GUARD) ? cfg.post_len : cfg.pre_len;

  esc_tick_timer #(.W(TIME_W)) u_guard (
    .clk(clk), .rst_n(rst_n), .clear(guard_clear), .advance(guard_adv),
    .limit(guard_lim), .reached(guard_met)
  );

  esc_tick_timer #(.W(TIME_W)) u_gap (
    .clk(clk), .rst_n(rst_n), .clear(gap_clear), .advance(gap_adv),
    .limit(cfg.gap_lim), .reached(gap_expired)
  );

  esc_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .rx_idle(rx_idle), .bit_tick(bit_tick), .cmd_char(cfg.cmd_char),
    .need(need), .guard_met(guard_met), .gap_expired(gap_expired),
    .state(state), .guard_clear(guard_clear), .guard_adv(guard_adv),
    .gap_clear(gap_clear), .gap_adv(gap_adv), .detect(detect)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end

  assign in_ready  = ready_q || rst_n;
  assign dbg_state = state;

  a_r2_no_backpressure: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> in_ready);

endmodule

// File: tb/esc_seq_detect_test.sv
`timescale 1ns/1ps
module esc_seq_detect_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = 8'h00;
  logic        rx_idle = 1'b1;
  logic        bit_tick = 1'b0;
  logic        cfg_load = 1'b0;
  logic [7:0]  cfg_char = 8'h00;
  logic [7:0]  cfg_count = 8'h00;
  logic [15:0] cfg_pre_idle = 16'h0;
  logic [15:0] cfg_post_idle = 16'h0;
  logic [15:0] cfg_gap = 16'h0;
  logic        detect;
  logic [1:0]  dbg_state;

  int checks = 0;
  int fails = 0;
  int tick_div = 1;
  int tick_ph = 0;
  int det_seen = 0;
  bit prev_det = 1'b0;
  bit done = 1'b0;

  // reference model state
  int m_st, m_cnt, m_gap, m_seen;
  bit m_det;
  int c_char, c_run, c_pre, c_post, c_gap;

  always #5 clk = ~clk;

  esc_seq_detect uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .rx_idle(rx_idle), .bit_tick(bit_tick),
    .cfg_load(cfg_load), .cfg_char(cfg_char), .cfg_count(cfg_count),
    .cfg_pre_idle(cfg_pre_idle), .cfg_post_idle(cfg_post_idle),
    .cfg_gap(cfg_gap), .detect(detect), .dbg_state(dbg_state)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference, stepped on every edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_gap = 0; m_seen = 0; m_det = 1'b0;
      c_char = 8'h2B; c_run = 3; c_pre = 2305; c_post = 2305; c_gap = 11;
    end else begin
      int need;
      int lim;
      bit met;
      need = (c_run == 0) ? 1 : c_run;
      lim = (m_st == 3) ? c_post : c_pre;
      met = (m_cnt >= lim);
      m_det = 1'b0;
      case (m_st)
        0: begin
          if (in_valid) m_cnt = 0;
          else if (met) begin m_st = 1; m_cnt = 0; end
          else if (!rx_idle) m_cnt = 0;
          else if (bit_tick) m_cnt = m_cnt + 1;
        end
        1: begin
          if (in_valid) begin
            if (in_data != c_char[7:0]) begin m_st = 0; m_cnt = 0; end
            else if (need == 1) begin m_st = 3; m_cnt = 0; end
            else begin m_st = 2; m_seen = 1; m_gap = 0; end
          end
        end
        2: begin
          if (in_valid) begin
            if (in_data != c_char[7:0]) begin m_st = 0; m_cnt = 0; end
            else if (m_seen + 1 >= need) begin m_st = 3; m_cnt = 0; end
            else begin m_seen++; m_gap = 0; end
          end else if (bit_tick) begin
            if (m_gap >= c_gap) begin m_st = 0; m_cnt = 0; end
            else m_gap++;
          end
        end
        default: begin
          if (in_valid) begin m_st = 0; m_cnt = 0; end
          else if (met) begin m_st = 0; m_cnt = 0; m_det = 1'b1; end
          else if (!rx_idle) m_cnt = 0;
          else if (bit_tick) m_cnt = m_cnt + 1;
        end
      endcase
      if (cfg_load) begin
        c_char = cfg_char; c_run = cfg_count; c_pre = cfg_pre_idle;
        c_post = cfg_post_idle; c_gap = cfg_gap;
      end
    end
  end

  // compare and monitor away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      check(dbg_state == m_st[1:0], "R9 state trace", dbg_state, m_st);
      check(detect == m_det, "R8 detect trace", detect, m_det);
      check(in_ready == 1'b1, "R2 ready", in_ready, 1);
      if (detect) det_seen++;
      if (detect && prev_det) check(1'b0, "R8 pulse width", 2, 1);
      prev_det = detect;
    end
    tick_ph = (tick_ph + 1 >= tick_div) ? 0 : tick_ph + 1;
    bit_tick = (tick_ph == 0);
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1; in_data = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic load_cfg(input logic [7:0] ch, input logic [7:0] n,
                          input int pre, input int post, input int gap);
    @(negedge clk);
    cfg_char = ch; cfg_count = n; cfg_pre_idle = 16'(pre);
    cfg_post_idle = 16'(post); cfg_gap = 16'(gap); cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic arm();
    send(8'h00);
    idle(14);
  endtask

  initial begin
    int d0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(dbg_state == 2'd0, "R1 reset state", dbg_state, 0);
    check(detect == 1'b0, "R1 reset detect", detect, 0);
    check(in_ready == 1'b1, "R1 R2 ready after reset", in_ready, 1);

    // R1 defaults end to end, tick every cycle
    idle(2320);
    check(dbg_state == 2'd1, "R1 R3 default pre-guard arms", dbg_state, 1);
    d0 = det_seen;
    send(8'h2B); idle(2); send(8'h2B); idle(2);
    check(dbg_state == 2'd2, "R9 inside run", dbg_state, 2);
    send(8'h2B);
    check(dbg_state == 2'd3, "R1 R5 default run of three", dbg_state, 3);
    idle(2320);
    check(det_seen - d0 == 1, "R8 one detection", det_seen - d0, 1);
    check(dbg_state == 2'd0, "R8 back to pre-guard", dbg_state, 0);

    // R10 small settings
    tick_div = 2;
    load_cfg(8'h41, 8'd3, 4, 3, 5);
    arm();
    check(dbg_state == 2'd1, "R10 new pre-guard", dbg_state, 1);
    send(8'h2B);
    check(dbg_state == 2'd0, "R10 old char no longer matches", dbg_state, 0);

    // R3 line not idle holds guard
    rx_idle = 1'b0;
    send(8'h00); idle(30);
    check(dbg_state == 2'd0, "R3 busy line blocks arming", dbg_state, 0);
    rx_idle = 1'b1;
    idle(12);
    check(dbg_state == 2'd1, "R3 arms after idle ticks", dbg_state, 1);

    // R4 mismatches
    send(8'h42);
    check(dbg_state == 2'd0, "R4 mismatch while armed", dbg_state, 0);
    arm();
    send(8'h41); send(8'h42);
    check(dbg_state == 2'd0, "R4 mismatch inside run", dbg_state, 0);

    // R6 gap limit
    arm();
    send(8'h41);
    idle(8);
    check(dbg_state == 2'd2, "R6 within gap limit", dbg_state, 2);
    idle(6);
    check(dbg_state == 2'd0, "R6 gap limit abandons", dbg_state, 0);

    // R7 byte in post-guard
    arm();
    d0 = det_seen;
    send(8'h41); send(8'h41); send(8'h41);
    check(dbg_state == 2'd3, "R7 reached post-guard", dbg_state, 3);
    idle(1);
    send(8'h41);
    check(dbg_state == 2'd0, "R7 byte aborts post-guard", dbg_state, 0);
    idle(20);
    check(det_seen == d0, "R7 no detection", det_seen - d0, 0);

    // R8 small detection
    arm();
    d0 = det_seen;
    send(8'h41); send(8'h41); send(8'h41);
    idle(10);
    check(det_seen - d0 == 1, "R8 detection with loaded guard", det_seen - d0, 1);

    // R5 count zero treated as one
    load_cfg(8'h41, 8'd0, 4, 3, 5);
    arm();
    d0 = det_seen;
    send(8'h41);
    check(dbg_state == 2'd3, "R5 zero count single char", dbg_state, 3);
    idle(10);
    check(det_seen - d0 == 1, "R5 zero count detects", det_seen - d0, 1);

    idle(5);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule